// File: doc/BRIEF.md
# SMBus Register-File Slave

This block is a two-wire serial slave that gives a host controller access to a small bank of 8-bit configuration registers. SCL and SDA are treated as open-drain lines: the block sees each line as an input and pulls SDA low through a drive-low enable. Both lines are oversampled by the block's system clock. Each register's contents are exposed on a flat bus so that the surrounding logic can use the settings directly.

The host chooses between two access styles with the top bit of the command byte. In single-byte access the host writes or reads one register at a 7-bit offset. In block access the transfer always starts at register 0 and walks upward one register per byte. A block write carries a byte-count byte, which the slave acknowledges and discards. A block read returns the number of implemented registers first and then the register contents.

One register mixes writable bits with three read-only bits that mirror the latched frequency-select straps. Another register is a fixed identification byte. The register bank is fully usable without the serial interface, because reset loads every register with its default value.

Top module: `smbus_regfile`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits are 0x69 (0xD2 for a write, 0xD3 for a read). Any other address is left unacknowledged, and the slave ignores the bus until the next START or STOP.
- R2: A command byte with bit 7 = 1 selects single-byte access at the offset in bits 6:0. A following data byte writes that register. After a repeated START and the read address, the slave returns that register.
- R3: A command byte with bit 7 = 0 selects block access starting at register 0. In a block write, the first byte after the command is a count byte that is acknowledged and not stored. The data bytes that follow fill registers 0, 1, 2 and so on in ascending order.
- R4: A block read first returns a count byte equal to the number of implemented registers (10). It then returns registers 0, 1, 2 and so on, continuing for as long as the master acknowledges.
- R5: In any read, a NACK from the master ends the transfer, and the slave stops driving SDA from then on.
- R6: After reset the registers hold these values:
  - offsets 0 to 5: FF, FE, FF, 00, 07, 00
  - offset 6: 18, with its low three bits showing the strap input
  - offset 7: 08
  - offsets 8 and 9: 40, 0E
- R7: Some register bits are read-only:
  - Bits 2:0 of register 6 always show the `strapIn` input, and writes to those bits have no effect.
  - Register 7 always reads 0x08, and writes to it have no effect.
- R8: An offset at or beyond register 10 reads as 0x00, and writes to such an offset change no register.
- R9: A START or STOP that arrives before the eighth bit of a byte aborts the transfer, and the partial byte is never written to a register.
- R10: When bit 5 of register 6 is 1, a block write has no count byte, so the first byte after the command is written to register 0.
- R11: The slave changes its SDA drive only while SCL is low. It holds SDA low for the whole ninth (acknowledge) clock of each byte that it acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases the line |
| strapIn | input | 3 | Latched frequency-select straps, readable in register 6 bits 2:0 |
| cfgBytes | output | 80 | Register contents; register k occupies bits 8k+7:8k |

## Verification
The assertions check on every cycle several rules that hold regardless of the traffic:
- the SDA drive only changes while the synchronized SCL is low;
- a foreign address is never acknowledged;
- a STOP always returns the controller to idle;
- a block command resets the register pointer to 0;
- neither the read-only strap bits nor an out-of-range write ever alter stored state.

Only the bench scenarios can show that whole transactions produce the right register contents and read data. These scenarios cover:
- the count handling in both block directions;
- the skip-count mode;
- the end-of-read NACK;
- aborted bytes leaving every register untouched.

// File: rtl/smbus_rf_pkg.sv
package smbus_rf_pkg;

  typedef enum logic [2:0] {
    M_IDLE, M_ADDR, M_CMD, M_COUNT, M_WDATA, M_RDATA, M_HOLD
  } busMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic setPtr;
    logic clrPtr;
    logic writeReg;
    logic loadTx;
    logic loadCount;
    logic shiftTx;
  } dpStrobe_t;

  function automatic logic [7:0] resetValue(input int idx);
    case (idx)
      0: resetValue = 8'hFF;
      1: resetValue = 8'hFE;
      2: resetValue = 8'hFF;
      3: resetValue = 8'h00;
      4: resetValue = 8'h07;
      5: resetValue = 8'h00;
      6: resetValue = 8'h18;
      7: resetValue = 8'h08;
      8: resetValue = 8'h40;
      9: resetValue = 8'h0E;
      default: resetValue = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbus_rf_datapath.sv
module smbus_rf_datapath
  import smbus_rf_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int STRAP_REG = 6,
  parameter int STRAP_W = 3,
  parameter int ID_REG = 7,
  parameter logic [7:0] ID_VALUE = 8'h08,
  parameter int SKIP_BIT = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdaBit,
  input  dpStrobe_t          stb,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [7:0]         rxByte,
  output logic               txBit,
  output logic               skipCount,
  output logic [NUM_REGS*8-1:0] cfgBytes
);
  localparam int PTR_W = 7;
  localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};
  localparam logic [7:0] STRAP_MASK = 8'hFF << STRAP_W;

  logic [PTR_W-1:0] ptr;
  logic [7:0] txShift;
  logic [7:0] readByte;
  logic [NUM_REGS*8-1:0] storeFlat;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    localparam logic [7:0] WMASK = (gi == ID_REG) ? 8'h00 :
                                   (gi == STRAP_REG) ? STRAP_MASK : 8'hFF;
    logic [7:0] store;
    always_ff @(posedge clk) begin
      if (!rstN) store <= resetValue(gi);
      else if (stb.writeReg && ptr == PTR_W'(gi))
        store <= (store & ~WMASK) | (rxByte & WMASK);
    end
    assign storeFlat[gi*8 +: 8] = store;
    if (gi == ID_REG) begin : g_id
      assign cfgBytes[gi*8 +: 8] = ID_VALUE;
    end else if (gi == STRAP_REG) begin : g_strap
      assign cfgBytes[gi*8 +: 8] = {store[7:STRAP_W], strapIn};
    end else begin : g_plain
      assign cfgBytes[gi*8 +: 8] = store;
    end
  end

  always_comb begin
    readByte = 8'h00;
    for (int k = 0; k < NUM_REGS; k++)
      if (ptr == PTR_W'(k)) readByte = cfgBytes[k*8 +: 8];
  end

  assign skipCount = cfgBytes[STRAP_REG*8 + SKIP_BIT];
  assign txBit = txShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      rxByte <= '0;
      txShift <= '0;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaBit};
      if (stb.setPtr) ptr <= rxByte[PTR_W-1:0];
      else if (stb.clrPtr) ptr <= '0;
      else if ((stb.writeReg || stb.loadTx) && ptr != PTR_MAX) ptr <= ptr + 1'b1;
      if (stb.loadCount) txShift <= 8'(NUM_REGS);
      else if (stb.loadTx) txShift <= readByte;
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assert_block_ptr_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrPtr |=> ptr == '0);
  assert_oob_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeReg && int'(ptr) >= NUM_REGS) |=> $stable(storeFlat));
  assert_strap_protect_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeReg && ptr == PTR_W'(STRAP_REG)) |=>
      storeFlat[STRAP_REG*8 +: STRAP_W] == $past(storeFlat[STRAP_REG*8 +: STRAP_W]));

endmodule

// File: rtl/smbus_rf_ctrl.sv
module smbus_rf_ctrl
  import smbus_rf_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic [7:0] rxByte,
  input  logic      txBit,
  input  logic      skipCount,
  output logic      sdaBit,
  output dpStrobe_t stb,
  output logic      sdaDriveLow
);
  logic [2:0] sclQ, sdaQ;
  logic sclLvl, sclPrev, sdaLvl, sdaPrev;
  logic riseEv, fallEv, startEv, stopEv, busEvt;

  busMode_t mode, modeN, afterMode, afterModeN;
  logic [3:0] bitCnt, bitCntN;
  logic ackDrive, ackDriveN, txDrive, txDriveN;
  logic blockOp, blockOpN, countPend, countPendN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
    end else begin
      sclQ <= {sclQ[1:0], sclIn};
      sdaQ <= {sdaQ[1:0], sdaIn};
    end
  end

  assign sclLvl  = sclQ[1];
  assign sclPrev = sclQ[2];
  assign sdaLvl  = sdaQ[1];
  assign sdaPrev = sdaQ[2];
  assign riseEv  = sclLvl & ~sclPrev;
  assign fallEv  = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
  assign busEvt  = startEv | stopEv;
  assign sdaBit  = sdaLvl;

  always_comb begin
    modeN = mode; afterModeN = afterMode; bitCntN = bitCnt;
    ackDriveN = ackDrive; txDriveN = txDrive;
    blockOpN = blockOp; countPendN = countPend;
    stb = '0;
    if (startEv) begin
      modeN = M_ADDR; bitCntN = '0; ackDriveN = 1'b0; txDriveN = 1'b0;
    end else if (stopEv) begin
      modeN = M_IDLE; bitCntN = '0; ackDriveN = 1'b0; txDriveN = 1'b0;
    end else if (riseEv) begin
      case (mode)
        M_ADDR, M_CMD, M_COUNT, M_WDATA:
          if (bitCnt < 4'd8) begin
            stb.shiftIn = 1'b1;
            bitCntN = bitCnt + 1'b1;
          end
        M_RDATA:
          if (bitCnt < 4'd8) bitCntN = bitCnt + 1'b1;
          else if (bitCnt == 4'd8) begin
            if (sdaLvl) begin
              modeN = M_HOLD; txDriveN = 1'b0;
            end else bitCntN = 4'd9;
          end
        default: ;
      endcase
    end else if (fallEv) begin
      if (mode == M_RDATA) begin
        if (bitCnt == 4'd8) txDriveN = 1'b0;
        else if (bitCnt == 4'd9) begin
          stb.loadTx = 1'b1; txDriveN = 1'b1; bitCntN = '0;
        end else if (bitCnt != 4'd0) stb.shiftTx = 1'b1;
      end else if (mode != M_IDLE && mode != M_HOLD && bitCnt == 4'd8) begin
        if (!ackDrive) begin
          ackDriveN = 1'b1;
          case (mode)
            M_ADDR:
              if (rxByte[7:1] == SLAVE_ADDR)
                afterModeN = rxByte[0] ? M_RDATA : M_CMD;
              else begin
                ackDriveN = 1'b0; modeN = M_HOLD;
              end
            M_CMD:
              if (rxByte[7]) begin
                stb.setPtr = 1'b1; blockOpN = 1'b0; afterModeN = M_WDATA;
              end else begin
                stb.clrPtr = 1'b1; blockOpN = 1'b1; countPendN = 1'b1;
                afterModeN = skipCount ? M_WDATA : M_COUNT;
              end
            M_COUNT: afterModeN = M_WDATA;
            default: stb.writeReg = 1'b1;
          endcase
        end else begin
          ackDriveN = 1'b0; bitCntN = '0; modeN = afterMode;
          if (afterMode == M_RDATA) begin
            txDriveN = 1'b1;
            if (blockOp && countPend) begin
              stb.loadCount = 1'b1; countPendN = 1'b0;
            end else stb.loadTx = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= M_IDLE; afterMode <= M_IDLE; bitCnt <= '0;
      ackDrive <= 1'b0; txDrive <= 1'b0; blockOp <= 1'b0; countPend <= 1'b0;
    end else begin
      mode <= modeN; afterMode <= afterModeN; bitCnt <= bitCntN;
      ackDrive <= ackDriveN; txDrive <= txDriveN;
      blockOp <= blockOpN; countPend <= countPendN;
    end
  end

  assign sdaDriveLow = ackDrive | (txDrive & ~txBit);

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaDriveLow) && !$past(busEvt)) |-> !sclLvl);
  assert_foreign_nack_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fallEv && !busEvt && mode == M_ADDR && bitCnt == 4'd8 && !ackDrive &&
     rxByte[7:1] != SLAVE_ADDR) |=> (!ackDrive && mode == M_HOLD));
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (mode == M_IDLE && !sdaDriveLow));

endmodule

// File: rtl/smbus_regfile.sv
module smbus_regfile
  import smbus_rf_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int STRAP_REG = 6,
  parameter int STRAP_W = 3,
  parameter int ID_REG = 7,
  parameter logic [7:0] ID_VALUE = 8'h08,
  parameter int SKIP_BIT = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [NUM_REGS*8-1:0] cfgBytes
);
  dpStrobe_t stb;
  logic sdaBit, txBit, skipCount;
  logic [7:0] rxByte;

  smbus_rf_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .skipCount(skipCount),
    .sdaBit(sdaBit), .stb(stb), .sdaDriveLow(sdaDriveLow)
  );

  smbus_rf_datapath #(
    .NUM_REGS(NUM_REGS), .STRAP_REG(STRAP_REG), .STRAP_W(STRAP_W),
    .ID_REG(ID_REG), .ID_VALUE(ID_VALUE), .SKIP_BIT(SKIP_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sdaBit(sdaBit), .stb(stb), .strapIn(strapIn),
    .rxByte(rxByte), .txBit(txBit), .skipCount(skipCount), .cfgBytes(cfgBytes)
  );

endmodule

// File: tb/smbus_regfile_test.sv
module smbus_regfile_test;
  localparam int N = 10;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic [2:0] strap = 3'b010;
  logic sdaDriveLow;
  logic [N*8-1:0] cfgBytes;
  wire sdaBus = mSda & ~sdaDriveLow;

  int vectors = 0;
  int fails = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;
  logic [7:0] model [N];

  always #10 clk = ~clk;

  smbus_regfile uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .strapIn(strap), .cfgBytes(cfgBytes)
  );

  function automatic logic [7:0] viewOf(input int i);
    if (i >= N) return 8'h00;
    if (i == 7) return 8'h08;
    if (i == 6) return {model[6][7:3], strap};
    return model[i];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison of the register view (R6, R7, R8, R9)
  always @(negedge clk) begin
    if (rstN && cmpOn && !finished)
      for (int i = 0; i < N; i++)
        check(cfgBytes[i*8 +: 8] == viewOf(i), "R6/R7/R8/R9 register view",
              {24'h0, cfgBytes[i*8 +: 8]}, {24'h0, viewOf(i)});
  end

  task automatic waitQ(input int k); repeat (k) @(negedge clk); endtask

  task automatic busStart;
    mSda = 1'b1; waitQ(Q); scl = 1'b1; waitQ(Q); mSda = 1'b0; waitQ(Q); scl = 1'b0; waitQ(Q);
  endtask

  task automatic busStop;
    mSda = 1'b0; waitQ(Q); scl = 1'b1; waitQ(Q); mSda = 1'b1; waitQ(2*Q);
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitQ(Q); scl = 1'b1; waitQ(2*Q); scl = 1'b0; waitQ(Q);
  endtask

  task automatic recvBit(output logic b);
    mSda = 1'b1; waitQ(Q); scl = 1'b1; waitQ(Q); b = sdaBus; waitQ(Q); scl = 1'b0; waitQ(Q);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic readByte(output logic [7:0] v, input logic masterAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); v[i] = b; end
    sendBit(~masterAck);
  endtask

  task automatic modelWrite(input int off, input logic [7:0] v);
    if (off < N && off != 7) begin
      if (off == 6) model[6] = {v[7:3], model[6][2:0]};
      else model[off] = v;
    end
  endtask

  task automatic byteWrite(input int off, input logic [7:0] v, input string tag);
    logic a;
    busStart;
    writeByte(8'hD2, a); check(a, {tag, " addr ack"}, a, 1);
    writeByte(8'h80 | 8'(off), a); check(a, {tag, " cmd ack"}, a, 1);
    cmpOn = 1'b0;
    writeByte(v, a); check(a, {tag, " data ack"}, a, 1);
    modelWrite(off, v);
    cmpOn = 1'b1;
    busStop;
  endtask

  task automatic byteRead(input int off, output logic [7:0] v);
    logic a;
    busStart;
    writeByte(8'hD2, a); check(a, "R2 read addrW ack", a, 1);
    writeByte(8'h80 | 8'(off), a); check(a, "R2 read cmd ack", a, 1);
    busStart;
    writeByte(8'hD3, a); check(a, "R2 read addrR ack", a, 1);
    readByte(v, 1'b0);
    busStop;
  endtask

  initial begin : main
    logic a;
    logic [7:0] v;
    logic [7:0] q [$];
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    model[0] = 8'hFF; model[1] = 8'hFE; model[2] = 8'hFF; model[3] = 8'h00;
    model[4] = 8'h07; model[5] = 8'h00; model[6] = 8'h18; model[8] = 8'h40; model[9] = 8'h0E;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R6 reset values
    for (int i = 0; i < N; i++)
      check(cfgBytes[i*8 +: 8] == viewOf(i), "R6 reset value", cfgBytes[i*8 +: 8], viewOf(i));
    check(sdaDriveLow == 1'b0, "R11 idle release", sdaDriveLow, 0);
    cmpOn = 1'b1;

    // R2 single byte write then read back
    byteWrite(3, 8'hA5, "R2");
    byteRead(3, v); check(v == 8'hA5, "R2 byte read", v, 8'hA5);
    byteRead(9, v); check(v == 8'h0E, "R2 byte read default", v, 8'h0E);

    // R1 foreign address gets NACK and changes nothing
    busStart; writeByte(8'hA4, a); check(!a, "R1 foreign addr nack", a, 0);
    writeByte(8'h83, a); check(!a, "R1 ignored cmd nack", a, 0);
    writeByte(8'h00, a); busStop;
    byteRead(3, v); check(v == 8'hA5, "R1 foreign write ignored", v, 8'hA5);

    // R3 block write with count byte
    busStart;
    writeByte(8'hD2, a); check(a, "R3 addr ack", a, 1);
    writeByte(8'h00, a); check(a, "R3 cmd ack", a, 1);
    writeByte(8'h03, a); check(a, "R3 count ack", a, 1);
    q = '{8'hA1, 8'hB2, 8'hC3};
    for (int i = 0; i < 3; i++) begin
      cmpOn = 1'b0; writeByte(q[i], a); check(a, "R3 data ack", a, 1);
      modelWrite(i, q[i]); cmpOn = 1'b1;
    end
    busStop;

    // R7 read-only bits and ID byte
    byteWrite(7, 8'h55, "R7");
    byteRead(7, v); check(v == 8'h08, "R7 id byte", v, 8'h08);
    byteWrite(6, 8'h87, "R7");
    byteRead(6, v); check(v == {5'b10000, strap}, "R7 strap bits", v, {5'b10000, strap});
    strap = 3'b101;
    byteRead(6, v); check(v == 8'h85, "R7 strap follows input", v, 8'h85);

    // R8 out of range
    byteWrite(8'h20, 8'h99, "R8");
    byteRead(8'h20, v); check(v == 8'h00, "R8 out of range read", v, 0);

    // R4 block read: count then registers, R5 NACK ends it
    busStart;
    writeByte(8'hD2, a); writeByte(8'h00, a); check(a, "R4 cmd ack", a, 1);
    busStart;
    writeByte(8'hD3, a); check(a, "R4 addrR ack", a, 1);
    readByte(v, 1'b1); check(v == 8'(N), "R4 count byte", v, N);
    for (int i = 0; i < N; i++) begin
      readByte(v, i != N - 1);
      check(v == viewOf(i), "R4 block data", v, viewOf(i));
    end
    waitQ(2);
    check(sdaDriveLow == 1'b0, "R5 released after nack", sdaDriveLow, 0);
    busStop;

    // R9 abort mid-byte by STOP and by repeated START
    busStart; writeByte(8'hD2, a); writeByte(8'h83, a);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop;
    busStart; writeByte(8'hD2, a); writeByte(8'h84, a);
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    busStart; busStop;
    byteRead(3, v); check(v == 8'hA5, "R9 abort by stop", v, 8'hA5);
    byteRead(4, v); check(v == 8'h07, "R9 abort by start", v, 8'h07);

    // R10 skip-count mode
    byteWrite(6, 8'h38, "R10");
    busStart; writeByte(8'hD2, a); writeByte(8'h00, a);
    cmpOn = 1'b0; writeByte(8'h11, a); modelWrite(0, 8'h11); cmpOn = 1'b1;
    cmpOn = 1'b0; writeByte(8'h22, a); modelWrite(1, 8'h22); cmpOn = 1'b1;
    busStop;
    byteRead(0, v); check(v == 8'h11, "R10 first byte to reg0", v, 8'h11);
    byteRead(1, v); check(v == 8'h22, "R10 second byte to reg1", v, 8'h22);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule